// File: doc/BRIEF.md
# Platform Status and Control Register Window

This block is a small register window on a 32-bit system bus. It reports fixed platform status to software: build identifiers, memory-controller health, per-port link state, reference-clock information, build options and the fitted memory size. It also takes one command, a request to reset the whole system. Software reaches it with single-beat requests. Every request receives a response exactly one cycle later. A request is described by a valid strobe, a write flag, an address, a byte count and write data.

Decoding uses the low 16 bits of the address, so the window repeats across higher address bits. Only accesses whose byte count equals the full word (4 bytes) are serviced. A narrower or wider access is acknowledged with zero data and has no side effect. A word-wide access to an offset the window does not implement is acknowledged with zero data and a raised unimplemented-access flag. Clock generation, memory calibration and link training live elsewhere. Their status is either constant here or arrives on input pins.

The response path is a five-state machine. Each cycle it moves to the state that describes the request just sampled:
- IDLE: no request.
- READ: a read reply that carries data.
- WRITE: a plain acknowledge.
- UNIMPL: an acknowledge with the flag raised.
- SOFT_RESET: an acknowledge with the reset pulse.

Any state can move to any other in one cycle, so back-to-back requests are answered back to back. Reset puts the machine in IDLE.

Top module: `plat_status_regs`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high in the next cycle, and a cycle without a request produces `rsp_valid` low. A write response carries zero data. After reset, all outputs are low.
- R2: The register is selected by `req_addr[15:0]`; bits above 15 are ignored, and offsets at or above 0x1000 are unimplemented.
- R3: Word reads of the build identifier (0x00) and the two change identifiers (0x04, 0x08) return 0.
- R4: A word read of the memory status register (0x14) returns 0x00000005: bit 0 means clock locked, bit 2 means calibrated.
- R5: A word read of the link status register (0x18) returns `pcie_lock[k]` at bit 8*k for each port k, with every other bit 0.
- R6: A word read of the clock information register (0x30) returns `refclk_mhz` in bits 15:8 and the value 1 in each of the byte fields at bits 7:0, 23:16 and 31:24.
- R7: A word read of the build options register (0x34) returns 0x0000000E: the three link ports are enabled and the coherency-unit bit 0 is clear.
- R8: A word read of the memory configuration register (0x38) returns `mem_gib` in bits 3:0, ones in bits 15:4 and zero above.
- R9: A request with `req_bytes` other than 4 is acknowledged with zero data. It raises neither the flag nor the reset pulse, whatever its offset or data.
- R10: A word write to 0x10 with `req_wdata[4]` set raises `sys_reset_req` for exactly the response cycle. The same write with bit 4 clear raises nothing.
- R11: Word writes to 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 are acknowledged without the flag and change no later read value.
- R12: A word access to any other offset sets `rsp_unimpl` in its response cycle with zero data. A word read of 0x10 is one of these, because that register is write-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; low 16 bits decoded |
| req_bytes | input | 4 | Access width in bytes; only 4 is serviced |
| req_wdata | input | 32 | Write data |
| refclk_mhz | input | 8 | Reference clock frequency in MHz |
| mem_gib | input | 4 | Fitted memory size in GiB |
| pcie_lock | input | 3 | Per-port link locked flags |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero unless a serviced read |
| rsp_unimpl | output | 1 | Response is to an unimplemented offset |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `req_valid` is low during reset and that the status inputs are stable in the cycle they are sampled with a read. The bench therefore drives requests only after reset is released, and changes the status inputs at a falling edge, together with the request that observes them. The assertions also assume that `req_bytes` and the low address bits are always driven to known values. The bench never leaves them undriven, and drives `req_valid` low in every idle cycle, so the one-cycle response rule is checked against a defined history.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

    localparam int OFF_W = 16;

    localparam logic [OFF_W-1:0] OFF_ID_BUILD  = 16'h0000;
    localparam logic [OFF_W-1:0] OFF_ID_CHG_A  = 16'h0004;
    localparam logic [OFF_W-1:0] OFF_ID_CHG_B  = 16'h0008;
    localparam logic [OFF_W-1:0] OFF_SOFTRST   = 16'h0010;
    localparam logic [OFF_W-1:0] OFF_MEM_STAT  = 16'h0014;
    localparam logic [OFF_W-1:0] OFF_LINK_STAT = 16'h0018;
    localparam logic [OFF_W-1:0] OFF_CLK_INFO  = 16'h0030;
    localparam logic [OFF_W-1:0] OFF_BUILD_OPT = 16'h0034;
    localparam logic [OFF_W-1:0] OFF_MEM_CFG   = 16'h0038;

    localparam int RESET_BIT = 4;

    typedef enum logic [2:0] {
        K_ID_ZERO,
        K_SOFTRST,
        K_MEM_STAT,
        K_LINK_STAT,
        K_CLK_INFO,
        K_BUILD_OPT,
        K_MEM_CFG,
        K_UNKNOWN
    } reg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_UNIMPL,
        ST_SOFT_RESET
    } rsp_state_e;

endpackage

// File: rtl/plat_offset_decode.sv
module plat_offset_decode
    import plat_regs_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    output reg_kind_e        kind
);

    always_comb begin
        unique case (offset)
            OFF_ID_BUILD,
            OFF_ID_CHG_A,
            OFF_ID_CHG_B:  kind = K_ID_ZERO;
            OFF_SOFTRST:   kind = K_SOFTRST;
            OFF_MEM_STAT:  kind = K_MEM_STAT;
            OFF_LINK_STAT: kind = K_LINK_STAT;
            OFF_CLK_INFO:  kind = K_CLK_INFO;
            OFF_BUILD_OPT: kind = K_BUILD_OPT;
            OFF_MEM_CFG:   kind = K_MEM_CFG;
            default:       kind = K_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/plat_read_mux.sv
module plat_read_mux
    import plat_regs_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MHZ_W    = 8,
    parameter int GIB_W    = 4,
    parameter int NUM_PCIE = 3
) (
    input  reg_kind_e            kind,
    input  logic [MHZ_W-1:0]     refclk_mhz,
    input  logic [GIB_W-1:0]     mem_gib,
    input  logic [NUM_PCIE-1:0]  pcie_lock,
    output logic [DATA_W-1:0]    rdata
);

    localparam int LANE_W       = 8;
    localparam int CLK0_LSB     = 0;
    localparam int CLK_IN_LSB   = 8;
    localparam int CLK_MUL_LSB  = 16;
    localparam int CLK1_LSB     = 24;
    localparam int MEM_MHZ_LSB  = 4;
    localparam int MEM_MHZ_W    = 12;
    localparam int MEM_LOCK_BIT = 0;
    localparam int MEM_CAL_BIT  = 2;
    localparam int LINK_USED_W  = NUM_PCIE * LANE_W;

    logic [DATA_W-1:0] link_word;
    logic [DATA_W-1:0] clk_word;
    logic [DATA_W-1:0] mem_stat_word;
    logic [DATA_W-1:0] build_word;
    logic [DATA_W-1:0] mem_cfg_word;

    for (genvar g = 0; g < NUM_PCIE; g++) begin : g_link_lane
        assign link_word[g*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, pcie_lock[g]};
    end
    if (LINK_USED_W < DATA_W) begin : g_link_pad
        assign link_word[DATA_W-1:LINK_USED_W] = '0;
    end

    always_comb begin
        clk_word                          = '0;
        clk_word[CLK0_LSB]                = 1'b1;
        clk_word[CLK_IN_LSB +: MHZ_W]     = refclk_mhz;
        clk_word[CLK_MUL_LSB]             = 1'b1;
        clk_word[CLK1_LSB]                = 1'b1;

        mem_stat_word                     = '0;
        mem_stat_word[MEM_LOCK_BIT]       = 1'b1;
        mem_stat_word[MEM_CAL_BIT]        = 1'b1;

        build_word                        = '0;
        for (int p = 0; p < NUM_PCIE; p++) begin
            build_word[p+1] = 1'b1;
        end

        mem_cfg_word                      = '0;
        mem_cfg_word[GIB_W-1:0]           = mem_gib;
        mem_cfg_word[MEM_MHZ_LSB +: MEM_MHZ_W] = '1;
    end

    always_comb begin
        unique case (kind)
            K_MEM_STAT:  rdata = mem_stat_word;
            K_LINK_STAT: rdata = link_word;
            K_CLK_INFO:  rdata = clk_word;
            K_BUILD_OPT: rdata = build_word;
            K_MEM_CFG:   rdata = mem_cfg_word;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/plat_ctrl_fsm.sv
module plat_ctrl_fsm
    import plat_regs_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int BYTES_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic               reset_bit,
    input  reg_kind_e          kind,
    input  logic [DATA_W-1:0]  rdata_next,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_unimpl,
    output logic               sys_reset_req
);

    localparam logic [BYTES_W-1:0] FULL_BYTES = BYTES_W'(DATA_W / 8);

    rsp_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              size_ok;

    assign size_ok = (req_bytes == FULL_BYTES);

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!size_ok) begin
                state_d = req_write ? ST_WRITE : ST_READ;
            end else if (req_write) begin
                unique case (kind)
                    K_SOFTRST: state_d = reset_bit ? ST_SOFT_RESET : ST_WRITE;
                    K_UNKNOWN: state_d = ST_UNIMPL;
                    default:   state_d = ST_WRITE;
                endcase
            end else begin
                unique case (kind)
                    K_SOFTRST,
                    K_UNKNOWN: state_d = ST_UNIMPL;
                    default:   state_d = ST_READ;
                endcase
            end
        end
        data_d = (state_d == ST_READ && size_ok) ? rdata_next : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        rsp_valid     = 1'b0;
        rsp_rdata     = '0;
        rsp_unimpl    = 1'b0;
        sys_reset_req = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                rsp_valid = 1'b1;
                rsp_rdata = data_q;
            end
            ST_WRITE: rsp_valid = 1'b1;
            ST_UNIMPL: begin
                rsp_valid  = 1'b1;
                rsp_unimpl = 1'b1;
            end
            ST_SOFT_RESET: begin
                rsp_valid     = 1'b1;
                sys_reset_req = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/plat_status_regs.sv
module plat_status_regs
    import plat_regs_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int BYTES_W  = 4,
    parameter int MHZ_W    = 8,
    parameter int GIB_W    = 4,
    parameter int NUM_PCIE = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [BYTES_W-1:0]  req_bytes,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [MHZ_W-1:0]    refclk_mhz,
    input  logic [GIB_W-1:0]    mem_gib,
    input  logic [NUM_PCIE-1:0] pcie_lock,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_unimpl,
    output logic                sys_reset_req
);

    reg_kind_e         kind;
    logic [DATA_W-1:0] rdata_next;
    logic              unused_bits;

    assign unused_bits = ^{req_addr[ADDR_W-1:OFF_W],
                           req_wdata[DATA_W-1:RESET_BIT+1],
                           req_wdata[RESET_BIT-1:0]};

    plat_offset_decode u_decode (
        .offset (req_addr[OFF_W-1:0]),
        .kind   (kind)
    );

    plat_read_mux #(
        .DATA_W   (DATA_W),
        .MHZ_W    (MHZ_W),
        .GIB_W    (GIB_W),
        .NUM_PCIE (NUM_PCIE)
    ) u_mux (
        .kind       (kind),
        .refclk_mhz (refclk_mhz),
        .mem_gib    (mem_gib),
        .pcie_lock  (pcie_lock),
        .rdata      (rdata_next)
    );

    plat_ctrl_fsm #(
        .DATA_W  (DATA_W),
        .BYTES_W (BYTES_W)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_bytes     (req_bytes),
        .reset_bit     (req_wdata[RESET_BIT]),
        .kind          (kind),
        .rdata_next    (rdata_next),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_unimpl    (rsp_unimpl),
        .sys_reset_req (sys_reset_req)
    );

endmodule

// File: rtl/plat_status_regs_chk.sv
module plat_status_regs_chk
    import plat_regs_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BYTES_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [BYTES_W-1:0] req_bytes,
    input logic [DATA_W-1:0]  req_wdata,
    input logic               rsp_valid,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               rsp_unimpl,
    input logic               sys_reset_req
);

    localparam logic [BYTES_W-1:0] WORD = BYTES_W'(DATA_W / 8);

    logic [OFF_W-1:0] off;
    logic             word_req;
    logic             unused_chk;

    assign off        = req_addr[OFF_W-1:0];
    assign word_req   = req_valid && (req_bytes == WORD);
    assign unused_chk = ^req_addr[ADDR_W-1:OFF_W];

    // R1: response exactly one cycle after each request
    p_rsp_timing_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid));

    // R4: memory status word
    p_mem_stat_r4: assert property (@(posedge clk) disable iff (rst)
        $past(word_req && !req_write && off == OFF_MEM_STAT) |-> rsp_rdata == 32'h5);

    // R9: bad-size accesses are quiet
    p_badsize_r9: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_bytes != WORD) |-> (!rsp_unimpl && !sys_reset_req && rsp_rdata == '0));

    // R10: reset pulse only after a qualifying write
    p_reset_src_r10: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> $past(word_req && req_write && off == OFF_SOFTRST && req_wdata[RESET_BIT]));

    // R12: unimplemented responses carry zero data
    p_unimpl_zero_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_unimpl |-> (rsp_valid && rsp_rdata == '0));

endmodule

bind plat_status_regs plat_status_regs_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BYTES_W (BYTES_W)
) u_chk (.*);

// File: tb/tb_plat_status_regs.sv
module tb_plat_status_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_bytes = 4'd4;
    logic [31:0] req_wdata = '0;
    logic [7:0]  refclk_mhz = 8'd50;
    logic [3:0]  mem_gib = 4'd2;
    logic [2:0]  pcie_lock = 3'b101;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_unimpl;
    logic        sys_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit          q_v[$];
    logic [31:0] q_d[$];
    bit          q_u[$];
    bit          q_r[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    plat_status_regs dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .refclk_mhz(refclk_mhz), .mem_gib(mem_gib), .pcie_lock(pcie_lock),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_unimpl(rsp_unimpl),
        .sys_reset_req(sys_reset_req)
    );

    task automatic push_exp(input bit v, input logic [31:0] d, input bit u, input bit r, input string tag);
        q_v.push_back(v);
        q_d.push_back(d);
        q_u.push_back(u);
        q_r.push_back(r);
        q_tag.push_back(tag);
    endtask

    task automatic do_req(input bit we, input logic [31:0] a, input logic [3:0] nb,
                          input logic [31:0] wd, input logic [31:0] ed,
                          input bit eu, input bit er, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = we;
        req_addr  = a;
        req_bytes = nb;
        req_wdata = wd;
        push_exp(1'b1, ed, eu, er, tag);
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        push_exp(1'b0, 32'h0, 1'b0, 1'b0, tag);
    endtask

    // monitor: compares each response one delta after the edge that produced it
    always @(posedge clk) begin
        #1;
        if (q_v.size() != 0) begin
            bit          ev;
            logic [31:0] ed;
            bit          eu;
            bit          er;
            string       tg;
            ev = q_v.pop_front();
            ed = q_d.pop_front();
            eu = q_u.pop_front();
            er = q_r.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (rsp_valid !== ev || rsp_rdata !== ed || rsp_unimpl !== eu || sys_reset_req !== er) begin
                errors++;
                $display("FAIL %s: actual v=%0b d=%h u=%0b r=%0b expected v=%0b d=%h u=%0b r=%0b",
                         tg, rsp_valid, rsp_rdata, rsp_unimpl, sys_reset_req, ev, ed, eu, er);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_rdata !== 32'h0 || rsp_unimpl !== 1'b0 || sys_reset_req !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: actual v=%0b d=%h u=%0b r=%0b expected all zero",
                     rsp_valid, rsp_rdata, rsp_unimpl, sys_reset_req);
        end
        rst = 1'b0;

        do_idle("R1 idle");
        do_req(0, 32'h0000_0000, 4, 0, 32'h0, 0, 0, "R3 build id");
        do_req(0, 32'h0000_0004, 4, 0, 32'h0, 0, 0, "R3 change id A");
        do_req(0, 32'h0000_0008, 4, 0, 32'h0, 0, 0, "R3 change id B");
        do_req(0, 32'h0000_0014, 4, 0, 32'h5, 0, 0, "R4 mem status");
        do_req(0, 32'hABCD_0014, 4, 0, 32'h5, 0, 0, "R2 high bits ignored");
        do_req(0, 32'h0000_1014, 4, 0, 32'h0, 1, 0, "R2 offset above window");
        do_req(0, 32'h0000_0018, 4, 0, 32'h0001_0001, 0, 0, "R5 link status 101");
        do_req(0, 32'h0000_0030, 4, 0, 32'h0101_3201, 0, 0, "R6 clock info 50MHz");
        do_req(0, 32'h0000_0034, 4, 0, 32'h0000_000E, 0, 0, "R7 build options");
        do_req(0, 32'h0000_0038, 4, 0, 32'h0000_FFF2, 0, 0, "R8 mem config 2GiB");
        do_idle("R1 gap");

        do_req(0, 32'h0000_0014, 2, 0, 32'h0, 0, 0, "R9 half read");
        do_req(1, 32'h0000_0010, 8, 32'h10, 32'h0, 0, 0, "R9 wide reset write");
        do_req(0, 32'h0000_001C, 1, 0, 32'h0, 0, 0, "R9 byte read unknown");

        do_req(1, 32'h0000_0010, 4, 32'h10, 32'h0, 0, 1, "R10 reset pulse");
        do_idle("R10 pulse ends");
        do_req(1, 32'h0000_0010, 4, 32'hFFFF_FFEF, 32'h0, 0, 0, "R10 bit4 clear");

        do_req(1, 32'h0000_0014, 4, 32'h0, 32'h0, 0, 0, "R11 write mem status");
        do_req(0, 32'h0000_0014, 4, 0, 32'h5, 0, 0, "R11 mem status kept");
        do_req(1, 32'h0000_0038, 4, 32'h0, 32'h0, 0, 0, "R11 write mem config");
        do_req(0, 32'h0000_0038, 4, 0, 32'h0000_FFF2, 0, 0, "R11 mem config kept");
        do_req(1, 32'h0000_0000, 4, 32'hFFFF_FFFF, 32'h0, 0, 0, "R11 write build id");
        do_req(0, 32'h0000_0000, 4, 0, 32'h0, 0, 0, "R11 build id kept");
        do_req(1, 32'h0000_0034, 4, 32'h1, 32'h0, 0, 0, "R11 write build options");
        do_req(0, 32'h0000_0034, 4, 0, 32'h0000_000E, 0, 0, "R11 build options kept");

        do_req(1, 32'h0000_001C, 4, 32'h1, 32'h0, 1, 0, "R12 write unknown");
        do_req(0, 32'h0000_0020, 4, 0, 32'h0, 1, 0, "R12 read unknown");
        do_req(0, 32'h0000_0010, 4, 0, 32'h0, 1, 0, "R12 read of write-only");
        do_req(0, 32'h0000_0FFC, 4, 0, 32'h0, 1, 0, "R12 read top of window");

        @(negedge clk);
        refclk_mhz = 8'd100;
        mem_gib    = 4'd1;
        pcie_lock  = 3'b010;
        req_valid  = 1'b1;
        req_write  = 1'b0;
        req_addr   = 32'h30;
        req_bytes  = 4'd4;
        push_exp(1'b1, 32'h0101_6401, 1'b0, 1'b0, "R6 clock info 100MHz");
        do_req(0, 32'h0000_0038, 4, 0, 32'h0000_FFF1, 0, 0, "R8 mem config 1GiB");
        do_req(0, 32'h0000_0018, 4, 0, 32'h0000_0100, 0, 0, "R5 link status 010");
        do_idle("R1 drain");
        do_idle("R1 drain");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule